// File: doc/BRIEF.md
# Two-Wire Slave Command Front End

This block is the bus-facing half of a small sensor-and-memory peripheral. It watches the clock and data lines of an open-drain two-wire serial bus through a system clock. It finds the start and stop framing conditions and receives the addressing byte. It answers only when a fixed four-bit device code and three strap-selected bits both match. It can pull the data line low, and the only output it uses for that is an enable. Outside the block, the enable drives the low side of the pad.

Once addressed for writing, the first byte that follows is a command. The command picks one of five jobs: the byte memory with its address pointer, the configuration byte, the two-byte temperature word, or a pulse that starts or stops conversions. The bytes that come after the command are passed to the back end as single-cycle write strobes. Reads work the other way. The back end puts a byte on its read port for the source and index the block presents, and the block shifts that byte out. Memory writes are only staged. A stop commits them and a repeated start aborts them, and the back end reports a running nonvolatile write through a busy input.

Top module: `tw_cmd_slave`

## Requirements
- R1: After reset, and whenever no acknowledge or transmit bit is in progress, `sda_oe` is 0. A low-going data edge while the clock is high restarts framing. A high-going data edge while the clock is high returns the block to idle.
- R2: The first byte after a start is acknowledged (`sda_oe`=1 in the ninth clock) only when its bits 7..4 equal `1001`, bits 3..1 equal `dev_sel`, and `nv_busy` is 0. Bit 0 set to 1 selects a read and 0 selects a write.
- R3: When an addressing byte is not acknowledged, the block ignores all bus activity until the next start. Later bytes get no acknowledge and produce no strobe.
- R4: While `nv_busy` is 1, a matching addressing byte is not acknowledged.
- R5: Each byte written to an addressed slave is acknowledged, and `sda_oe` stays 1 for the whole high phase of the ninth clock.
- R6: Read bytes are sent MSB first. A master acknowledge (data low in the ninth clock) causes the next byte to be loaded. A master not-acknowledge releases the line, and no further bit is driven until a start.
- R7: After command 17h, the next write byte loads the memory pointer. Each following byte gives `wr_stb`=1 with `wr_cfg`=0, `wr_addr` equal to the pointer, and `wr_data` equal to the byte. The pointer's low 3 bits then increment modulo 8 and its upper bits are kept.
- R8: With command 17h, reads present `rd_src`=0 and `rd_addr` equal to the pointer. The pointer increments by one across its full width after each loaded byte, wrapping from FFh to 00h.
- R9: After command ACh, write bytes give `wr_stb` with `wr_cfg`=1 and `wr_addr`=0. Reads present `rd_src`=1.
- R10: After command AAh, reads present `rd_src`=2 with `rd_addr`=0 for the first byte (high) and 1 for the second byte (low).
- R11: Command EEh gives a one-cycle `conv_start` pulse and command 22h gives a one-cycle `conv_stop` pulse. At most one of the strobes `wr_stb`, `conv_start`, `conv_stop`, `commit_stb` and `abort_stb` is high in any cycle.
- R12: A stop that ends a transaction containing at least one write strobe gives a one-cycle `commit_stb`. A start in that situation gives `abort_stb` instead. Transactions without writes give neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bus clock |
| rst_n | input | 1 | Synchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_oe | output | 1 | 1 pulls the data line low |
| dev_sel | input | 3 | Strap-selected low address bits |
| nv_busy | input | 1 | Nonvolatile write cycle in progress |
| rd_src | output | 2 | Read source: 0 memory, 1 configuration, 2 temperature, 3 none |
| rd_addr | output | 8 | Read index within the source |
| rd_data | input | 8 | Byte returned by the back end for rd_src/rd_addr |
| wr_stb | output | 1 | One-cycle write strobe |
| wr_cfg | output | 1 | Write targets configuration (1) or memory (0) |
| wr_addr | output | 8 | Write address |
| wr_data | output | 8 | Write data |
| commit_stb | output | 1 | Staged writes must be programmed |
| abort_stb | output | 1 | Staged writes must be discarded |
| conv_start | output | 1 | Begin temperature conversions |
| conv_stop | output | 1 | Halt temperature conversions |

## Verification
The bench builds the block with its default parameters: device code 1001, an 8-bit pointer, a 3-bit page field and a two-flop synchronizer. Those values put the eight-byte page rollover within reach of a ten-byte burst, and the FFh-to-00h read wrap within reach of a four-byte read. A back-end model in the bench stages writes and applies or drops them on commit or abort. Every memory check therefore reads back over the bus and depends on the framing at both ends of the transaction.

// File: rtl/tws_pkg.sv
// Shared constants and types for the two-wire command slave.
// Assumes 8-bit bus bytes; opcode values are fixed by the command protocol.
package tws_pkg;
    localparam logic [7:0] OP_MEM       = 8'h17;
    localparam logic [7:0] OP_CFG       = 8'hAC;
    localparam logic [7:0] OP_TEMP      = 8'hAA;
    localparam logic [7:0] OP_CONV_GO   = 8'hEE;
    localparam logic [7:0] OP_CONV_HALT = 8'h22;

    typedef enum logic [1:0] {
        SRC_MEM  = 2'd0,
        SRC_CFG  = 2'd1,
        SRC_TEMP = 2'd2,
        SRC_NONE = 2'd3
    } rd_src_e;

    typedef enum logic [2:0] {
        B_IDLE,
        B_ADDR,
        B_RX,
        B_ACK,
        B_TX,
        B_MACK
    } bit_state_e;
endpackage

// File: rtl/tws_line_sync.sv
// Synchronizes the bus lines into the system clock and flags edges and
// framing conditions. Assumes STAGES >= 2; idle bus lines read as 1.
module tws_line_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_i,
    input  logic sda_i,
    output logic scl_lvl,
    output logic sda_lvl,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_ev,
    output logic stop_ev
);
    localparam int TOP = STAGES - 1;

    logic [TOP:0] scl_pipe, sda_pipe;
    logic         scl_q, sda_q;

    // Shift the raw lines through the synchronizer and keep one prior sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            scl_pipe <= '1;
            sda_pipe <= '1;
            scl_q    <= 1'b1;
            sda_q    <= 1'b1;
        end else begin
            scl_pipe <= {scl_pipe[TOP-1:0], scl_i};
            sda_pipe <= {sda_pipe[TOP-1:0], sda_i};
            scl_q    <= scl_pipe[TOP];
            sda_q    <= sda_pipe[TOP];
        end
    end

    assign scl_lvl  = scl_pipe[TOP];
    assign sda_lvl  = sda_pipe[TOP];
    assign scl_rise = scl_lvl & ~scl_q;
    assign scl_fall = ~scl_lvl & scl_q;
    assign start_ev = scl_lvl & scl_q & sda_q & ~sda_lvl;
    assign stop_ev  = scl_lvl & scl_q & ~sda_q & sda_lvl;
endmodule

// File: rtl/tws_bit_engine.sv
// Bit and byte framing: address match, acknowledge generation, byte receive
// and byte transmit with master-acknowledge handling. Framing conditions take
// priority over data edges. Assumes events from tws_line_sync.
module tws_bit_engine
    import tws_pkg::*;
#(
    parameter logic [3:0] DEV_CODE = 4'b1001
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sda_lvl,
    input  logic       scl_rise,
    input  logic       scl_fall,
    input  logic       start_ev,
    input  logic       stop_ev,
    input  logic [2:0] dev_sel,
    input  logic       nv_busy,
    input  logic [7:0] tx_byte,
    output logic       sda_oe,
    output logic       hit_stb,
    output logic       hit_rw,
    output logic       rx_stb,
    output logic [7:0] rx_byte,
    output logic       tx_load
);
    bit_state_e state;
    logic [2:0] bitcnt;
    logic [7:0] shreg;
    logic       full_q, ack_q, mack_ok;
    logic [7:0] incoming;

    assign incoming = {shreg[6:0], sda_lvl};

    // Main framing state machine; one register set, pulses default low.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state   <= B_IDLE;
            bitcnt  <= '0;
            shreg   <= '0;
            full_q  <= 1'b0;
            ack_q   <= 1'b0;
            mack_ok <= 1'b0;
            sda_oe  <= 1'b0;
            hit_stb <= 1'b0;
            hit_rw  <= 1'b0;
            rx_stb  <= 1'b0;
            rx_byte <= '0;
            tx_load <= 1'b0;
        end else begin
            hit_stb <= 1'b0;
            rx_stb  <= 1'b0;
            tx_load <= 1'b0;
            if (start_ev) begin
                state  <= B_ADDR;
                bitcnt <= '0;
                full_q <= 1'b0;
                sda_oe <= 1'b0;
            end else if (stop_ev) begin
                state  <= B_IDLE;
                full_q <= 1'b0;
                sda_oe <= 1'b0;
            end else begin
                unique case (state)
                    B_ADDR, B_RX: begin
                        if (scl_rise) begin
                            shreg  <= incoming;
                            bitcnt <= bitcnt + 3'd1;
                            if (bitcnt == 3'd7) begin
                                full_q <= 1'b1;
                                if (state == B_ADDR) begin
                                    ack_q <= (incoming[7:4] == DEV_CODE) &&
                                             (incoming[3:1] == dev_sel) && !nv_busy;
                                    if ((incoming[7:4] == DEV_CODE) &&
                                        (incoming[3:1] == dev_sel) && !nv_busy) begin
                                        hit_stb <= 1'b1;
                                        hit_rw  <= incoming[0];
                                    end
                                end else begin
                                    ack_q   <= 1'b1;
                                    rx_stb  <= 1'b1;
                                    rx_byte <= incoming;
                                end
                            end
                        end else if (scl_fall && full_q) begin
                            full_q <= 1'b0;
                            if (ack_q) begin
                                sda_oe <= 1'b1;
                                state  <= B_ACK;
                            end else begin
                                state  <= B_IDLE;
                            end
                        end
                    end
                    B_ACK: begin
                        if (scl_fall) begin
                            bitcnt <= '0;
                            if (hit_rw) begin
                                state   <= B_TX;
                                shreg   <= tx_byte;
                                sda_oe  <= ~tx_byte[7];
                                tx_load <= 1'b1;
                            end else begin
                                state  <= B_RX;
                                sda_oe <= 1'b0;
                            end
                        end
                    end
                    B_TX: begin
                        if (scl_fall) begin
                            if (bitcnt == 3'd7) begin
                                sda_oe <= 1'b0;
                                state  <= B_MACK;
                            end else begin
                                shreg  <= {shreg[6:0], 1'b0};
                                sda_oe <= ~shreg[6];
                                bitcnt <= bitcnt + 3'd1;
                            end
                        end
                    end
                    B_MACK: begin
                        if (scl_rise) begin
                            mack_ok <= ~sda_lvl;
                        end else if (scl_fall) begin
                            bitcnt <= '0;
                            if (mack_ok) begin
                                state   <= B_TX;
                                shreg   <= tx_byte;
                                sda_oe  <= ~tx_byte[7];
                                tx_load <= 1'b1;
                            end else begin
                                state <= B_IDLE;
                            end
                        end
                    end
                    default: ;
                endcase
            end
        end
    end
endmodule

// File: rtl/tws_cmd_unit.sv
// Command layer: decodes the first write byte as an opcode, keeps the memory
// pointer and temperature byte index, issues write strobes and conversion
// pulses, and turns framing into commit or abort of staged writes.
// Assumes the bit engine's hit/rx/tx_load pulses are one cycle wide.
module tws_cmd_unit
    import tws_pkg::*;
#(
    parameter int ADDR_W = 8,
    parameter int PAGE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_ev,
    input  logic              stop_ev,
    input  logic              hit_stb,
    input  logic              hit_rw,
    input  logic              rx_stb,
    input  logic [7:0]        rx_byte,
    input  logic              tx_load,
    output logic [1:0]        rd_src,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_stb,
    output logic              wr_cfg,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              commit_stb,
    output logic              abort_stb,
    output logic              conv_start,
    output logic              conv_stop
);
    logic [7:0]        opcode;
    logic [1:0]        widx;
    logic [ADDR_W-1:0] ptr;
    logic              tidx;
    logic              pend;

    // Opcode, pointer and strobe sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            opcode     <= '0;
            widx       <= '0;
            ptr        <= '0;
            tidx       <= 1'b0;
            pend       <= 1'b0;
            wr_stb     <= 1'b0;
            wr_cfg     <= 1'b0;
            wr_addr    <= '0;
            wr_data    <= '0;
            commit_stb <= 1'b0;
            abort_stb  <= 1'b0;
            conv_start <= 1'b0;
            conv_stop  <= 1'b0;
        end else begin
            wr_stb     <= 1'b0;
            commit_stb <= 1'b0;
            abort_stb  <= 1'b0;
            conv_start <= 1'b0;
            conv_stop  <= 1'b0;
            if (start_ev) begin
                abort_stb <= pend;
                pend      <= 1'b0;
            end else if (stop_ev) begin
                commit_stb <= pend;
                pend       <= 1'b0;
            end
            if (hit_stb && !hit_rw) widx <= '0;
            if (rx_stb) begin
                if (widx != 2'd2) widx <= widx + 2'd1;
                if (widx == 2'd0) begin
                    opcode     <= rx_byte;
                    tidx       <= 1'b0;
                    conv_start <= (rx_byte == OP_CONV_GO);
                    conv_stop  <= (rx_byte == OP_CONV_HALT);
                end else if (opcode == OP_MEM) begin
                    if (widx == 2'd1) begin
                        ptr <= ADDR_W'(rx_byte);
                    end else begin
                        wr_stb  <= 1'b1;
                        wr_cfg  <= 1'b0;
                        wr_addr <= ptr;
                        wr_data <= rx_byte;
                        ptr     <= {ptr[ADDR_W-1:PAGE_W], ptr[PAGE_W-1:0] + PAGE_W'(1)};
                        pend    <= 1'b1;
                    end
                end else if (opcode == OP_CFG) begin
                    wr_stb  <= 1'b1;
                    wr_cfg  <= 1'b1;
                    wr_addr <= '0;
                    wr_data <= rx_byte;
                    pend    <= 1'b1;
                end
            end
            if (tx_load) begin
                if (opcode == OP_MEM)  ptr  <= ptr + ADDR_W'(1);
                if (opcode == OP_TEMP) tidx <= ~tidx;
            end
        end
    end

    // Read source and index presented to the back end.
    always_comb begin
        rd_src  = SRC_NONE;
        rd_addr = '0;
        if (opcode == OP_MEM) begin
            rd_src  = SRC_MEM;
            rd_addr = ptr;
        end else if (opcode == OP_CFG) begin
            rd_src  = SRC_CFG;
        end else if (opcode == OP_TEMP) begin
            rd_src  = SRC_TEMP;
            rd_addr = ADDR_W'(tidx);
        end
    end
endmodule

// File: rtl/tw_cmd_slave.sv
// Top of the two-wire command slave: line synchronizer, bit engine and
// command unit. Assumes the system clock is at least 8x the bus clock and
// that the pad turns sda_oe into an open-drain pull-down.
module tw_cmd_slave #(
    parameter logic [3:0] DEV_CODE    = 4'b1001,
    parameter int         ADDR_W      = 8,
    parameter int         PAGE_W      = 3,
    parameter int         SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scl_i,
    input  logic              sda_i,
    output logic              sda_oe,
    input  logic [2:0]        dev_sel,
    input  logic              nv_busy,
    output logic [1:0]        rd_src,
    output logic [ADDR_W-1:0] rd_addr,
    input  logic [7:0]        rd_data,
    output logic              wr_stb,
    output logic              wr_cfg,
    output logic [ADDR_W-1:0] wr_addr,
    output logic [7:0]        wr_data,
    output logic              commit_stb,
    output logic              abort_stb,
    output logic              conv_start,
    output logic              conv_stop
);
    logic       scl_lvl, sda_lvl, scl_rise, scl_fall, start_ev, stop_ev;
    logic       hit_stb, hit_rw, rx_stb, tx_load;
    logic [7:0] rx_byte;

    tws_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .scl_i(scl_i), .sda_i(sda_i),
        .scl_lvl(scl_lvl), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev)
    );

    tws_bit_engine #(.DEV_CODE(DEV_CODE)) u_bits (
        .clk(clk), .rst_n(rst_n), .sda_lvl(sda_lvl), .scl_rise(scl_rise),
        .scl_fall(scl_fall), .start_ev(start_ev), .stop_ev(stop_ev),
        .dev_sel(dev_sel), .nv_busy(nv_busy), .tx_byte(rd_data),
        .sda_oe(sda_oe), .hit_stb(hit_stb), .hit_rw(hit_rw),
        .rx_stb(rx_stb), .rx_byte(rx_byte), .tx_load(tx_load)
    );

    tws_cmd_unit #(.ADDR_W(ADDR_W), .PAGE_W(PAGE_W)) u_cmd (
        .clk(clk), .rst_n(rst_n), .start_ev(start_ev), .stop_ev(stop_ev),
        .hit_stb(hit_stb), .hit_rw(hit_rw), .rx_stb(rx_stb), .rx_byte(rx_byte),
        .tx_load(tx_load), .rd_src(rd_src), .rd_addr(rd_addr),
        .wr_stb(wr_stb), .wr_cfg(wr_cfg), .wr_addr(wr_addr), .wr_data(wr_data),
        .commit_stb(commit_stb), .abort_stb(abort_stb),
        .conv_start(conv_start), .conv_stop(conv_stop)
    );
endmodule

// File: rtl/tws_slave_chk.sv
// Protocol checker for tw_cmd_slave, attached by bind. Observes the top's
// ports plus the synchronized clock level.
module tws_slave_chk (
    input logic clk,
    input logic rst_n,
    input logic scl_sync,
    input logic sda_oe,
    input logic wr_stb,
    input logic commit_stb,
    input logic abort_stb,
    input logic conv_start,
    input logic conv_stop
);
    // R1: reset leaves the data line released.
    assert_reset_quiet_R1: assert property (@(posedge clk)
        !rst_n |=> !sda_oe);

    // R5: the pull-down only moves while the synchronized clock is low.
    assert_oe_moves_low_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !$stable(sda_oe) |-> !$past(scl_sync));

    // R11: strobes toward the back end never overlap.
    assert_strobe_exclusive_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_stb, commit_stb, abort_stb, conv_start, conv_stop}));

    // R11: conversion requests last one cycle.
    assert_conv_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (conv_start || conv_stop) |=> !(conv_start || conv_stop));

    // R12: commit and abort last one cycle.
    assert_end_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (commit_stb || abort_stb) |=> !(commit_stb || abort_stb));
endmodule

bind tw_cmd_slave tws_slave_chk u_chk (
    .clk(clk), .rst_n(rst_n), .scl_sync(scl_lvl), .sda_oe(sda_oe),
    .wr_stb(wr_stb), .commit_stb(commit_stb), .abort_stb(abort_stb),
    .conv_start(conv_start), .conv_stop(conv_stop)
);

// File: tb/tw_cmd_slave_test.sv
module tw_cmd_slave_test;
    localparam int Q = 6;
    localparam logic [2:0] SEL = 3'b101;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic scl = 1'b1, sda_m = 1'b1;
    logic nv_busy = 1'b0;
    logic [2:0] dev_sel = SEL;
    logic sda_oe, wr_stb, wr_cfg, commit_stb, abort_stb, conv_start, conv_stop;
    logic [1:0] rd_src;
    logic [7:0] rd_addr, wr_addr, wr_data;
    logic [7:0] rd_data;
    wire sda_line = sda_m & ~sda_oe;

    int n_chk = 0, n_bad = 0, cyc = 0;
    int n_commit = 0, n_abort = 0, n_go = 0, n_halt = 0, n_wr = 0;

    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];
    logic [7:0] cfg_reg = 8'h00;
    logic [15:0] temp_word = 16'h1910;
    logic [7:0] st_a [16], st_d [16];
    logic       st_c [16];
    int st_n = 0;

    always #2 clk = ~clk;

    tw_cmd_slave uut (
        .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_line), .sda_oe(sda_oe),
        .dev_sel(dev_sel), .nv_busy(nv_busy), .rd_src(rd_src), .rd_addr(rd_addr),
        .rd_data(rd_data), .wr_stb(wr_stb), .wr_cfg(wr_cfg), .wr_addr(wr_addr),
        .wr_data(wr_data), .commit_stb(commit_stb), .abort_stb(abort_stb),
        .conv_start(conv_start), .conv_stop(conv_stop)
    );

    // Back-end model: read mux from the block's source/index outputs.
    always_comb begin
        case (rd_src)
            2'd0: rd_data = mem[rd_addr];
            2'd1: rd_data = cfg_reg;
            2'd2: rd_data = rd_addr[0] ? temp_word[7:0] : temp_word[15:8];
            default: rd_data = 8'hFF;
        endcase
    end

    // Back-end model: staged writes, applied on commit, dropped on abort.
    always @(negedge clk) begin
        if (wr_stb) begin
            n_wr++;
            if (st_n < 16) begin
                st_a[st_n] = wr_addr; st_d[st_n] = wr_data; st_c[st_n] = wr_cfg; st_n++;
            end
        end
        if (commit_stb) begin
            n_commit++;
            for (int k = 0; k < st_n; k++)
                if (st_c[k]) cfg_reg = st_d[k]; else mem[st_a[k]] = st_d[k];
            st_n = 0;
        end
        if (abort_stb) begin n_abort++; st_n = 0; end
        if (conv_start) n_go++;
        if (conv_stop) n_halt++;
    end

    task automatic summary();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    endtask

    // Watchdog: a hung run counts as a failed check.
    always @(negedge clk) begin
        cyc++;
        if (cyc > 190000) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog actual=%0d expected<190000", cyc);
            summary();
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wq(); repeat (Q) @(negedge clk); endtask

    task automatic b_start();
        wq(); sda_m = 1'b1; wq(); scl = 1'b1; wq(); sda_m = 1'b0; wq(); scl = 1'b0;
    endtask

    task automatic b_stop();
        wq(); sda_m = 1'b0; wq(); scl = 1'b1; wq(); sda_m = 1'b1; wq();
    endtask

    // Sends one byte; ack=1 when the line is low at both ends of the ninth high phase.
    task automatic b_send(input logic [7:0] b, output logic ack);
        logic a1, a2;
        for (int i = 7; i >= 0; i--) begin
            wq(); sda_m = b[i]; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0;
        end
        wq(); sda_m = 1'b1; wq(); scl = 1'b1;
        @(negedge clk); a1 = sda_line;
        wq(); a2 = sda_line;
        wq(); scl = 1'b0;
        ack = !a1 && !a2;
    endtask

    task automatic b_recv(input logic mack, output logic [7:0] b);
        for (int i = 7; i >= 0; i--) begin
            wq(); sda_m = 1'b1; wq(); scl = 1'b1; wq(); b[i] = sda_line; wq(); scl = 1'b0;
        end
        wq(); sda_m = ~mack; wq(); scl = 1'b1; wq(); wq(); scl = 1'b0;
    endtask

    function automatic logic [7:0] ctl(input logic rd);
        return {4'b1001, SEL, rd};
    endfunction

    function automatic logic [7:0] page_step(input logic [7:0] a, input int k);
        logic [2:0] lo;
        lo = a[2:0] + 3'(k);
        return {a[7:3], lo};
    endfunction

    task automatic send_ok(input logic [7:0] b, input string tag);
        logic ack;
        b_send(b, ack);
        chk(ack, tag, ack, 1);
    endtask

    task automatic mem_write(input logic [7:0] a, input int n, input bit random_data);
        logic [7:0] d;
        int c0;
        c0 = n_commit;
        b_start(); send_ok(ctl(0), "R2 addr"); send_ok(8'h17, "R5 op"); send_ok(a, "R5 ptr");
        for (int k = 0; k < n; k++) begin
            d = random_data ? 8'($urandom) : 8'(k * 8'h11);
            send_ok(d, "R5 data");
            exp_mem[page_step(a, k)] = d;
        end
        b_stop(); wq();
        chk(n_commit == c0 + 1, "R12 commit", n_commit, c0 + 1);
    endtask

    task automatic mem_read(input logic [7:0] a, input int n);
        logic [7:0] b;
        b_start(); send_ok(ctl(0), "R2 addr"); send_ok(8'h17, "R5 op"); send_ok(a, "R5 ptr");
        b_start(); send_ok(ctl(1), "R2 read addr");
        for (int k = 0; k < n; k++) begin
            b_recv(k != n - 1, b);
            chk(b == exp_mem[8'(a + k)], "R8 mem read", b, exp_mem[8'(a + k)]);
        end
        b_stop();
    endtask

    initial begin
        logic ack;
        logic [7:0] b;
        int w0, c0;
        void'($urandom(32'd4711));
        for (int i = 0; i < 256; i++) begin
            mem[i] = 8'(i) ^ 8'h5A;
            exp_mem[i] = 8'(i) ^ 8'h5A;
        end
        repeat (5) @(negedge clk);
        chk(sda_oe == 1'b0, "R1 reset oe", sda_oe, 0);
        rst_n = 1'b1;
        repeat (5) @(negedge clk);
        chk(sda_oe == 1'b0 && wr_stb == 1'b0, "R1 idle", sda_oe, 0);

        // R3: wrong device code, then a matching byte without a new start.
        w0 = n_wr;
        b_start(); b_send({4'b1010, SEL, 1'b0}, ack);
        chk(!ack, "R3 wrong code", ack, 0);
        b_send(ctl(0), ack);
        chk(!ack, "R3 ignored until start", ack, 0);
        b_send(8'hAC, ack);
        chk(!ack && n_wr == w0, "R3 no strobe", n_wr, w0);
        b_stop();

        // R2: wrong select bits.
        b_start(); b_send({4'b1001, ~SEL, 1'b0}, ack);
        chk(!ack, "R2 wrong select", ack, 0);
        b_stop();

        // R4: busy back end refuses its own address.
        nv_busy = 1'b1;
        b_start(); b_send(ctl(0), ack);
        chk(!ack, "R4 busy nack", ack, 0);
        b_stop();
        nv_busy = 1'b0;

        // R9 and R12: configuration write then read.
        c0 = n_commit;
        b_start(); send_ok(ctl(0), "R2 addr"); send_ok(8'hAC, "R5 op"); send_ok(8'h5B, "R5 cfg data");
        b_stop(); wq();
        chk(n_commit == c0 + 1 && cfg_reg == 8'h5B, "R9 cfg write", cfg_reg, 8'h5B);
        b_start(); send_ok(ctl(0), "R2 addr"); send_ok(8'hAC, "R5 op");
        b_start(); send_ok(ctl(1), "R2 read addr");
        b_recv(1'b0, b);
        chk(b == 8'h5B, "R9 cfg read", b, 8'h5B);
        b_stop(); wq();
        chk(n_commit == c0 + 1, "R12 no commit on read", n_commit, c0 + 1);

        // R10: temperature word, high then low.
        b_start(); send_ok(ctl(0), "R2 addr"); send_ok(8'hAA, "R5 op");
        b_start(); send_ok(ctl(1), "R2 read addr");
        b_recv(1'b1, b);
        chk(b == 8'h19, "R10 temp high", b, 8'h19);
        b_recv(1'b0, b);
        chk(b == 8'h10, "R10 temp low", b, 8'h10);
        // R6: after a master NACK the slave drives nothing.
        ack = 1'b1;
        for (int i = 0; i < 9; i++) begin
            wq(); sda_m = 1'b1; wq(); scl = 1'b1; wq(); ack &= sda_line; wq(); scl = 1'b0;
        end
        chk(ack, "R6 released after nack", ack, 1);
        b_stop();

        // R11: conversion start and stop pulses.
        b_start(); send_ok(ctl(0), "R2 addr"); send_ok(8'hEE, "R11 go"); b_stop(); wq();
        chk(n_go == 1 && n_halt == 0, "R11 conv_start", n_go, 1);
        b_start(); send_ok(ctl(0), "R2 addr"); send_ok(8'h22, "R11 halt"); b_stop(); wq();
        chk(n_halt == 1 && n_go == 1, "R11 conv_stop", n_halt, 1);

        // R7: ten bytes from 00h overwrite the first two of the page.
        mem_write(8'h00, 10, 1'b0);
        chk(exp_mem[0] == 8'h88 && exp_mem[1] == 8'h99, "R7 model", exp_mem[0], 8'h88);
        mem_read(8'h00, 8);
        chk(mem[8] == 8'h52, "R7 next page untouched", mem[8], 8'h52);

        // R12: repeated start aborts the staged write.
        c0 = n_commit;
        w0 = n_abort;
        b_start(); send_ok(ctl(0), "R2 addr"); send_ok(8'h17, "R5 op"); send_ok(8'h40, "R5 ptr");
        send_ok(8'hC3, "R5 data");
        b_start(); b_stop(); wq();
        chk(n_abort == w0 + 1 && n_commit == c0, "R12 abort", n_abort, w0 + 1);
        chk(mem[8'h40] == exp_mem[8'h40], "R12 data dropped", mem[8'h40], exp_mem[8'h40]);

        // R8: read pointer wraps from FFh to 00h.
        mem_read(8'hFE, 4);

        // R6/R7/R8: random bursts.
        for (int it = 0; it < 12; it++) begin
            logic [7:0] a;
            a = 8'($urandom);
            mem_write(a, 1 + int'($urandom % 12), 1'b1);
            mem_read(a, 1 + int'($urandom % 10));
        end

        summary();
        $finish;
    end

    initial begin
        rst_n = 1'b0;
    end
endmodule